// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block keeps the exception part of a floating-point status register up to date. Each finished arithmetic operation hands over a 5-bit set of raised exception flags. The block weighs that set against the trap-enable field held in the register, then rewrites the current-exception field. It also updates either the accrued-exception field or the trap-type field. One cycle later it tells the pipeline whether the operation must trap or may retire.

Operations arrive on a valid/ready stream. `op_ready` drops only in a cycle where software writes the whole register through the load port. In such a cycle the write wins and the operation is not consumed. The producer keeps `op_valid` and `op_flags` steady until a cycle with `op_ready` high takes them. The full register is visible at all times on `stat_q`.

Top module: `fsr_exc_recorder`

## Requirements
- R1: After reset `stat_q` is zero and `trap_o` and `retire_o` are low.
- R2: An operation is taken in a cycle with `op_valid` and `op_ready` both high. In the next cycle exactly one of `trap_o` or `retire_o` is high for one cycle. `trap_o` is chosen when `op_flags` shares a set bit with the trap-enable field `stat_q[27:23]`; otherwise `retire_o` is chosen.
- R3: Flag bits are ordered the same way in `op_flags` and in every field: invalid at bit 4, overflow at 3, underflow at 2, divide-by-zero at 1, inexact at 0. On a trap the flags are masked by the enables, and only the highest-numbered remaining bit is written into the current field `stat_q[4:0]`.
- R4: On a retire the current field `stat_q[4:0]` takes `op_flags` unchanged, and the flags are ORed into the accrued field `stat_q[9:5]`.
- R5: On a trap the accrued field `stat_q[9:5]` keeps its value, and the trap-type field `stat_q[16:14]` becomes 3'd1.
- R6: On a retire the trap-type field `stat_q[16:14]` becomes 0.
- R7: An operation with no flags set retires, clears the current field and leaves the accrued field as it was.
- R8: With `sw_wr_en` high, `stat_q` takes `sw_wr_data` in the next cycle and `op_ready` is low. An operation offered in that cycle is held, and it takes effect after a later accepting cycle.
- R9: Bits of `stat_q` outside the current, accrued and trap-type fields are never changed by an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation's flags are offered |
| op_ready | output | 1 | Operation accepted this cycle when high together with op_valid |
| op_flags | input | 5 | Raised exception flags, order as in R3 |
| sw_wr_en | input | 1 | Software load of the whole register |
| sw_wr_data | input | 32 | Value to load |
| stat_q | output | 32 | Current status register contents |
| trap_o | output | 1 | One-cycle pulse: the taken operation must trap |
| retire_o | output | 1 | One-cycle pulse: the taken operation may retire |

## Verification
All state lives in `stat_q`, so any wrong field value shows on the port in the cycle right after the operation that caused it, together with its trap or retire pulse. A broken priority reducer shows as more than one bit, or the wrong bit, in the current field on a trap. A wrong accrued merge shows as lost or extra accrued bits. The sweep covers every flag set against every enable mask, each starting from a freshly loaded register, so a fault in any field surfaces within two cycles of the first operation that exposes it.

// File: rtl/fsr_exc_pkg.sv
package fsr_exc_pkg;
  localparam int unsigned NFLAG    = 5;
  localparam int unsigned CUR_LSB  = 0;
  localparam int unsigned ACC_LSB  = 5;
  localparam int unsigned TT_LSB   = 14;
  localparam int unsigned TT_W     = 3;
  localparam int unsigned EN_LSB   = 23;
  localparam logic [TT_W-1:0] TT_IEEE = 3'd1;
  typedef logic [NFLAG-1:0] exc_flags_t;
endpackage

// File: rtl/fsr_exc_filter.sv
module fsr_exc_filter
  import fsr_exc_pkg::*;
#(
  parameter int unsigned NF = NFLAG
) (
  input  logic [NF-1:0] flags_i,
  input  logic [NF-1:0] enable_i,
  output logic          trap_o,
  output logic [NF-1:0] rec_o
);
  logic [NF-1:0] hit;
  logic [NF-1:0] keep;

  assign hit    = flags_i & enable_i;
  assign trap_o = |hit;

  // Higher bit index means higher priority.
  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_pri
      if (i == NF - 1) begin : g_top
        assign keep[i] = hit[i];
      end else begin : g_low
        assign keep[i] = hit[i] & ~(|hit[NF-1:i+1]);
      end
    end
  endgenerate

  assign rec_o = trap_o ? keep : flags_i;
endmodule

// File: rtl/fsr_field_merge.sv
module fsr_field_merge
  import fsr_exc_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  parameter int unsigned NF    = NFLAG
) (
  input  logic [REG_W-1:0] cur_i,
  input  logic [NF-1:0]    rec_i,
  input  logic             trap_i,
  output logic [REG_W-1:0] nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    nxt_o[CUR_LSB +: NF] = rec_i;
    if (trap_i) begin
      nxt_o[TT_LSB +: TT_W] = TT_IEEE;
    end else begin
      nxt_o[ACC_LSB +: NF]  = cur_i[ACC_LSB +: NF] | rec_i;
      nxt_o[TT_LSB +: TT_W] = '0;
    end
  end
endmodule

// File: rtl/fsr_exc_recorder.sv
module fsr_exc_recorder
  import fsr_exc_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [NFLAG-1:0] op_flags,
  input  logic             sw_wr_en,
  input  logic [REG_W-1:0] sw_wr_data,
  output logic [REG_W-1:0] stat_q,
  output logic             trap_o,
  output logic             retire_o
);
  localparam logic [REG_W-1:0] FIELD_MASK =
      (REG_W'((1 << NFLAG) - 1) << CUR_LSB) |
      (REG_W'((1 << NFLAG) - 1) << ACC_LSB) |
      (REG_W'((1 << TT_W) - 1) << TT_LSB);
  localparam logic [REG_W-1:0] KEEP_MASK = ~FIELD_MASK;

  logic             take;
  logic             trap_c;
  logic [NFLAG-1:0] rec_c;
  logic [REG_W-1:0] merged;

  assign op_ready = ~sw_wr_en;
  assign take     = op_valid & op_ready;

  fsr_exc_filter #(.NF(NFLAG)) u_filter (
    .flags_i  (op_flags),
    .enable_i (stat_q[EN_LSB +: NFLAG]),
    .trap_o   (trap_c),
    .rec_o    (rec_c)
  );

  fsr_field_merge #(.REG_W(REG_W), .NF(NFLAG)) u_merge (
    .cur_i  (stat_q),
    .rec_i  (rec_c),
    .trap_i (trap_c),
    .nxt_o  (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= '0;
      trap_o   <= 1'b0;
      retire_o <= 1'b0;
    end else begin
      trap_o   <= take & trap_c;
      retire_o <= take & ~trap_c;
      if (sw_wr_en) begin
        stat_q <= sw_wr_data;
      end else if (take) begin
        stat_q <= merged;
      end
    end
  end

  // R2
  trap_retire_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_o, retire_o}));

  // R2
  op_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (trap_o || retire_o));

  // R3
  trap_single_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $onehot(stat_q[CUR_LSB +: NFLAG]));

  // R5
  trap_accr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (stat_q[ACC_LSB +: NFLAG] == $past(stat_q[ACC_LSB +: NFLAG])));

  // R5
  trap_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (stat_q[TT_LSB +: TT_W] == TT_IEEE));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> (stat_q == $past(sw_wr_data)) && !trap_o && !retire_o);

  // R9
  other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((stat_q & KEEP_MASK) == ($past(stat_q) & KEEP_MASK)));
endmodule

// File: tb/fsr_exc_recorder_bench.sv
module fsr_exc_recorder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [4:0]  op_flags = '0;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic [31:0] stat_q;
  logic        trap_o;
  logic        retire_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fsr_exc_recorder u_fsr_exc_recorder (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_flags(op_flags), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .stat_q(stat_q), .trap_o(trap_o), .retire_o(retire_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] v);
    @(negedge clk);
    sw_wr_en = 1'b1; sw_wr_data = v;
    @(negedge clk);
    sw_wr_en = 1'b0;
  endtask

  // Expected result of one operation on register pre with flags f.
  task automatic model(input logic [31:0] pre, input logic [4:0] f,
                       output logic [31:0] exp, output logic tr);
    logic [4:0] hit, rec;
    bit found;
    hit = f & pre[27:23];
    exp = pre;
    tr  = (hit != 0);
    if (tr) begin
      rec = '0; found = 1'b0;
      for (int b = 4; b >= 0; b--) begin
        if (hit[b] && !found) begin rec[b] = 1'b1; found = 1'b1; end
      end
      exp[4:0]   = rec;
      exp[16:14] = 3'd1;
    end else begin
      exp[4:0]   = f;
      exp[9:5]   = pre[9:5] | f;
      exp[16:14] = 3'd0;
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pre, exp;
    logic tr;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 stat_q", stat_q, 32'h0);
    check("R1 trap_o", {31'b0, trap_o}, 32'h0);
    check("R1 retire_o", {31'b0, retire_o}, 32'h0);
    rst_n = 1'b1;

    // Exhaustive sweep: every flag set against every enable mask.
    for (int m = 0; m < 32; m++) begin
      for (int f = 0; f < 32; f++) begin
        pre = 32'h9000_0000 | 32'h0000_2800 | (32'd5 << 14)
            | (32'(m) << 23) | (32'((f ^ (m * 3)) & 31) << 5) | 32'((m * 7 + 1) & 31);
        load(pre);
        check("R8 load value", stat_q, pre);
        model(pre, 5'(f), exp, tr);
        @(negedge clk);
        op_valid = 1'b1; op_flags = 5'(f);
        @(negedge clk);
        op_valid = 1'b0;
        // R2 R3 R4 R5 R6 R7 R9 whole register and pulses
        if (tr) check("R3 R5 R9 trap register", stat_q, exp);
        else if (f == 0) check("R7 R6 empty-flag register", stat_q, exp);
        else check("R4 R6 R9 retire register", stat_q, exp);
        check("R2 trap pulse", {31'b0, trap_o}, {31'b0, tr});
        check("R2 retire pulse", {31'b0, retire_o}, {31'b0, ~tr});
      end
    end

    // R2 pulses last one cycle
    @(negedge clk);
    check("R2 pulse ends", {30'b0, trap_o, retire_o}, 32'h0);

    // R8 load and op in the same cycle: load wins, op held
    load(32'h0080_0000);            // enable inexact only
    @(negedge clk);
    sw_wr_en = 1'b1; sw_wr_data = 32'h0100_0000; // enable divide-by-zero only
    op_valid = 1'b1; op_flags = 5'b00011;
    #0.5;
    check("R8 ready low", {31'b0, op_ready}, 32'h0);
    @(negedge clk);
    sw_wr_en = 1'b0;
    check("R8 load wins", stat_q, 32'h0100_0000);
    check("R8 no pulse", {30'b0, trap_o, retire_o}, 32'h0);
    @(negedge clk);
    op_valid = 1'b0;
    check("R8 held op traps", stat_q, 32'h0100_4002);
    check("R8 held op trap pulse", {31'b0, trap_o}, 32'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule